// File: doc/BRIEF.md
# Streaming Top-K Score Keeper

This block watches a stream of (score, document id) pairs and keeps the K highest scores seen since the last clear, each paired with the id that came with it. It is meant to sit behind a similarity engine that emits one dot-product score per candidate. Once every candidate has passed through, the retained list is read in parallel and used for voting.

The K entries sit in a register array sorted in ascending order, so slot 0 always holds the weakest survivor. A new score is first compared against slot 0. Most scores in a long stream are below that threshold and are dropped after this single comparison. A score that beats slot 0 pushes it out and takes its sorted place in the same cycle. All slots compare in parallel and the slots below the insertion point shift down by one. A clear pulse empties the list back to zero scores so that a new query can start.

Top module: `topk_sorter`

## Requirements
- R1: After reset, and at once while the asynchronous reset is asserted, every slot holds score 0 and id 0.
- R2: A clear pulse returns every slot to score 0 and id 0 on the next edge. A clear in the same cycle as a valid input wins, and that input is dropped.
- R3: A valid input whose score is less than or equal to the slot 0 score is discarded, and the whole array stays unchanged.
- R4: A valid input whose score is strictly greater than the slot 0 score evicts slot 0. Each slot whose score is strictly smaller moves down one place, and the new entry lands just below the first slot whose score is greater than or equal to it. The array stays ascending.
- R5: When scores tie, the new entry lands below the existing equal entries, so an earlier arrival stays at a higher slot index.
- R6: The block accepts one input in every cycle, back to back. The result of an insertion appears on the readout one clock edge after the input is sampled.
- R7: Each retained score carries the id that arrived with it through every shift.
- R8: With valid low and clear low, the array does not change, whatever is on the score and id inputs.
- R9: The readout is unsigned. Slot i occupies bits [i*SCORE_W +: SCORE_W] of the score bus and bits [i*ID_W +: ID_W] of the id bus. Slot 0 is the smallest score and slot K-1 the largest.
- R10: A score larger than every retained score goes into slot K-1, and the old top entry moves to slot K-2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr_i | input | 1 | Empties the list on the next edge |
| in_valid_i | input | 1 | Marks a score/id pair on the inputs |
| in_score_i | input | SCORE_W | Unsigned candidate score |
| in_id_i | input | ID_W | Document id paired with the score |
| rank_score_o | output | K*SCORE_W | Retained scores, slot 0 lowest |
| rank_id_o | output | K*ID_W | Ids matching the retained scores |

## Verification
Suppose a slot is loaded when it should shift, or a comparison is off by one on ties. Then the readout shows a misplaced or duplicated score, or an id that no longer belongs to its score, on the edge right after the offending input. The table-driven sequence therefore compares the full readout against a behavioural model after every cycle. A wrong slot 0 threshold shows up one step later, when an input that should have been dropped is admitted or one that should have been admitted is dropped. Ordering faults also break the ascending invariant, and the checker tests that invariant on every edge.

// File: rtl/topk_pkg.sv
package topk_pkg;

  localparam int unsigned TOPK_K_DEF       = 30;
  localparam int unsigned TOPK_SCORE_W_DEF = 32;
  localparam int unsigned TOPK_ID_W_DEF    = 20;

  // What a slot does on an accepted insertion
  typedef enum logic [1:0] {
    SLOT_HOLD  = 2'd0,
    SLOT_SHIFT = 2'd1,  // take the entry from the slot above
    SLOT_LOAD  = 2'd2   // take the incoming entry
  } slot_op_e;

endpackage

// File: rtl/topk_rst_sync.sv
module topk_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/topk_compare.sv
module topk_compare #(
  parameter int unsigned K       = topk_pkg::TOPK_K_DEF,
  parameter int unsigned SCORE_W = topk_pkg::TOPK_SCORE_W_DEF
) (
  input  logic [SCORE_W-1:0]        in_score_i,
  input  logic [K-1:0][SCORE_W-1:0] slot_score_i,
  output logic [K-1:0]              gt_o
);

  // One strict comparator per slot. The array is ascending, so gt_o is a
  // run of ones starting at bit 0.
  for (genvar s = 0; s < K; s++) begin : g_cmp
    assign gt_o[s] = (in_score_i > slot_score_i[s]);
  end

endmodule

// File: rtl/topk_slot_ctrl.sv
module topk_slot_ctrl
  import topk_pkg::*;
#(
  parameter int unsigned K = topk_pkg::TOPK_K_DEF
) (
  input  logic             in_valid_i,
  input  logic [K-1:0]     gt_i,
  output logic             accept_o,
  output logic [K-1:0][1:0] op_o
);

  // Only the slot 0 comparison decides admission
  assign accept_o = in_valid_i & gt_i[0];

  for (genvar s = 0; s < K; s++) begin : g_op
    if (s == K - 1) begin : g_top
      assign op_o[s] = !accept_o ? SLOT_HOLD :
                       gt_i[s]   ? SLOT_LOAD : SLOT_HOLD;
    end else begin : g_mid
      assign op_o[s] = !accept_o             ? SLOT_HOLD  :
                       (gt_i[s] & gt_i[s+1]) ? SLOT_SHIFT :
                       gt_i[s]               ? SLOT_LOAD  : SLOT_HOLD;
    end
  end

endmodule

// File: rtl/topk_sorter.sv
module topk_sorter
  import topk_pkg::*;
#(
  parameter int unsigned K       = topk_pkg::TOPK_K_DEF,
  parameter int unsigned SCORE_W = topk_pkg::TOPK_SCORE_W_DEF,
  parameter int unsigned ID_W    = topk_pkg::TOPK_ID_W_DEF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 in_valid_i,
  input  logic [SCORE_W-1:0]   in_score_i,
  input  logic [ID_W-1:0]      in_id_i,
  output logic [K*SCORE_W-1:0] rank_score_o,
  output logic [K*ID_W-1:0]    rank_id_o
);

  localparam int unsigned ENTRY_W = SCORE_W + ID_W;

  logic                          rst_n;
  logic [K-1:0][SCORE_W-1:0]     score_q, score_d;
  logic [K-1:0][ID_W-1:0]        id_q, id_d;
  logic [K-1:0]                  gt;
  logic [K-1:0][1:0]             op;
  logic                          accept;
  logic                          upd_en;

  topk_rst_sync u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  topk_compare #(
    .K       (K),
    .SCORE_W (SCORE_W)
  ) u_compare (
    .in_score_i   (in_score_i),
    .slot_score_i (score_q),
    .gt_o         (gt)
  );

  topk_slot_ctrl #(
    .K (K)
  ) u_slot_ctrl (
    .in_valid_i (in_valid_i),
    .gt_i       (gt),
    .accept_o   (accept),
    .op_o       (op)
  );

  // Next state per slot; clear overrides any insertion
  for (genvar s = 0; s < K; s++) begin : g_next
    logic [ENTRY_W-1:0] above;
    if (s == K - 1) begin : g_top
      assign above = {in_score_i, in_id_i};
    end else begin : g_mid
      assign above = {score_q[s+1], id_q[s+1]};
    end
    assign {score_d[s], id_d[s]} =
      clr_i                     ? '0                       :
      (op[s] == 2'(SLOT_SHIFT)) ? above                    :
      (op[s] == 2'(SLOT_LOAD))  ? {in_score_i, in_id_i}    :
                                  {score_q[s], id_q[s]};
  end

  assign upd_en = clr_i | accept;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      score_q <= '0;
      id_q    <= '0;
    end else if (upd_en) begin
      score_q <= score_d;
      id_q    <= id_d;
    end
  end

  assign rank_score_o = score_q;
  assign rank_id_o    = id_q;

endmodule

// File: rtl/topk_sorter_chk.sv
module topk_sorter_chk #(
  parameter int unsigned K       = 30,
  parameter int unsigned SCORE_W = 32,
  parameter int unsigned ID_W    = 20
) (
  input logic                 clk_i,
  input logic                 rst_n,
  input logic                 clr_i,
  input logic                 in_valid_i,
  input logic [SCORE_W-1:0]   in_score_i,
  input logic [K*SCORE_W-1:0] rank_score_o,
  input logic [K*ID_W-1:0]    rank_id_o
);

  logic [SCORE_W-1:0] low_s, top_s;
  assign low_s = rank_score_o[SCORE_W-1:0];
  assign top_s = rank_score_o[K*SCORE_W-1 -: SCORE_W];

  // R2
  clear_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    clr_i |=> (rank_score_o == '0) && (rank_id_o == '0));

  // R8
  idle_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!clr_i && !in_valid_i) |=> ($stable(rank_score_o) && $stable(rank_id_o)));

  // R3
  reject_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!clr_i && in_valid_i && (in_score_i <= low_s))
      |=> ($stable(rank_score_o) && $stable(rank_id_o)));

  // R4
  threshold_rises_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !clr_i |=> (low_s >= $past(low_s)));

  // R10
  winner_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!clr_i && in_valid_i && (in_score_i > low_s)) |=> (top_s >= $past(in_score_i)));

  for (genvar s = 0; s + 1 < K; s++) begin : g_ord
    // R4
    ascending_order_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
      rank_score_o[s*SCORE_W +: SCORE_W] <= rank_score_o[(s+1)*SCORE_W +: SCORE_W]);
  end

endmodule

bind topk_sorter topk_sorter_chk #(
  .K       (K),
  .SCORE_W (SCORE_W),
  .ID_W    (ID_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_n        (rst_n),
  .clr_i        (clr_i),
  .in_valid_i   (in_valid_i),
  .in_score_i   (in_score_i),
  .rank_score_o (rank_score_o),
  .rank_id_o    (rank_id_o)
);

// File: tb/topk_sorter_tb.sv
`timescale 1ns/1ps
module topk_sorter_tb;

  localparam int BK = 4;
  localparam int SW = 32;
  localparam int IW = 20;
  localparam int NV = 16;

  // {clr, valid, score, id}
  localparam logic [53:0] VEC [NV] = '{
    {1'b0, 1'b1, 32'd3,          20'd1},
    {1'b0, 1'b1, 32'd3,          20'd2},
    {1'b0, 1'b1, 32'd0,          20'd3},
    {1'b0, 1'b1, 32'd7,          20'd4},
    {1'b0, 1'b1, 32'd1,          20'd5},
    {1'b0, 1'b1, 32'd1,          20'd6},
    {1'b0, 1'b0, 32'd100,        20'd7},
    {1'b0, 1'b1, 32'd2,          20'd8},
    {1'b0, 1'b1, 32'hFFFF_FFFF,  20'd9},
    {1'b0, 1'b1, 32'd3,          20'd10},
    {1'b0, 1'b1, 32'd5,          20'd11},
    {1'b1, 1'b1, 32'd50,         20'd12},
    {1'b0, 1'b1, 32'd9,          20'd13},
    {1'b0, 1'b1, 32'd9,          20'd14},
    {1'b0, 1'b1, 32'd9,          20'd15},
    {1'b0, 1'b1, 32'd4,          20'd16}
  };

  logic              clk;
  logic              rst_n;
  logic              clr;
  logic              vld;
  logic [SW-1:0]     score;
  logic [IW-1:0]     id;
  logic [BK*SW-1:0]  rank_s;
  logic [BK*IW-1:0]  rank_i;

  logic [SW-1:0] m_s [BK];
  logic [IW-1:0] m_i [BK];

  int checks = 0;
  int fails  = 0;

  topk_sorter #(.K(BK), .SCORE_W(SW), .ID_W(IW)) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .clr_i        (clr),
    .in_valid_i   (vld),
    .in_score_i   (score),
    .in_id_i      (id),
    .rank_score_o (rank_s),
    .rank_id_o    (rank_i)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic model_clear();
    for (int k = 0; k < BK; k++) begin
      m_s[k] = '0;
      m_i[k] = '0;
    end
  endtask

  // Behavioural insertion: find the landing slot, then slide lower entries down
  task automatic model_step(input logic c, input logic v,
                            input logic [SW-1:0] s, input logic [IW-1:0] d);
    int p;
    if (c) begin
      model_clear();
    end else if (v && s > m_s[0]) begin
      p = 0;
      while (p + 1 < BK && s > m_s[p+1]) p++;
      for (int k = 0; k < p; k++) begin
        m_s[k] = m_s[k+1];
        m_i[k] = m_i[k+1];
      end
      m_s[p] = s;
      m_i[p] = d;
    end
  endtask

  task automatic cmp_all(input string tag);
    logic [BK*SW-1:0] es;
    logic [BK*IW-1:0] ei;
    for (int k = 0; k < BK; k++) begin
      es[k*SW +: SW] = m_s[k];
      ei[k*IW +: IW] = m_i[k];
    end
    checks++;
    if (rank_s !== es || rank_i !== ei) begin
      fails++;
      $display("FAIL %s scores got %h exp %h ids got %h exp %h",
               tag, rank_s, es, rank_i, ei);
    end
  endtask

  task automatic drive(input logic c, input logic v,
                       input logic [SW-1:0] s, input logic [IW-1:0] d);
    clr = c; vld = v; score = s; id = d;
    @(posedge clk);
    model_step(c, v, s, d);
    @(negedge clk);
    clr = 1'b0; vld = 1'b0;
  endtask

  function automatic string tag_of(input logic c, input logic v, input logic [SW-1:0] s);
    int eq;
    if (c) return "R2";
    if (!v) return "R8";
    if (s <= m_s[0]) return "R3";
    eq = 0;
    for (int k = 0; k < BK; k++) if (m_s[k] == s) eq = 1;
    if (eq != 0) return "R5 R7";
    return "R4 R6 R7";
  endfunction

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    string t;
    rst_n = 1'b0; clr = 1'b0; vld = 1'b0; score = '0; id = '0;
    model_clear();
    #10;
    cmp_all("R1 during reset");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cmp_all("R1 after reset");

    // Table walk: one vector per cycle, back to back (R6)
    for (int n = 0; n < NV; n++) begin
      t = tag_of(VEC[n][53], VEC[n][52], VEC[n][51:20]);
      drive(VEC[n][53], VEC[n][52], VEC[n][51:20], VEC[n][19:0]);
      cmp_all(t);
    end

    // R10: new maximum goes to the top slot
    drive(1'b0, 1'b1, 32'hFFFF_FFFE, 20'h12345);
    cmp_all("R10");
    checks++;
    if (rank_s[BK*SW-1 -: SW] !== 32'hFFFF_FFFE || rank_i[BK*IW-1 -: IW] !== 20'h12345) begin
      fails++;
      $display("FAIL R10 top got %h/%h exp fffffffe/12345",
               rank_s[BK*SW-1 -: SW], rank_i[BK*IW-1 -: IW]);
    end

    // R9: slot 0 holds the smallest retained score
    checks++;
    if (rank_s[SW-1:0] !== 32'd9) begin
      fails++;
      $display("FAIL R9 slot0 got %0d exp 9", rank_s[SW-1:0]);
    end

    // R3: exactly equal to the threshold is rejected
    drive(1'b0, 1'b1, 32'd9, 20'd77);
    cmp_all("R3 equal threshold");

    // R8: idle cycles with noisy data leave the array alone
    score = 32'hFFFF_FFFF; id = 20'hFFFFF;
    repeat (2) @(negedge clk);
    cmp_all("R8 idle");

    // R2: clear alone
    drive(1'b1, 1'b0, 32'd0, 20'd0);
    cmp_all("R2 clear");

    // R1: asynchronous reset mid-run clears before any edge
    drive(1'b0, 1'b1, 32'd42, 20'd42);
    cmp_all("R4 refill");
    rst_n = 1'b0;
    #1;
    model_clear();
    cmp_all("R1 async");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    drive(1'b0, 1'b1, 32'd8, 20'd8);
    cmp_all("R4 after reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule